// File: doc/BRIEF.md
# Ethernet PHY Management Bus Master

This block runs single register transactions on the two-wire Ethernet PHY management bus: a management clock (MDC) and one shared, bidirectional data line (MDIO). A host pulses `start` with a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, 16 data bits. The block then produces a complete frame on the bus. When the frame ends it raises `done` for one system clock. Read data appear on `rd_data`, and a PHY that fails to answer a read sets `no_resp`.

MDC comes from the system clock. Each MDC level lasts `DIV_HALF` system clocks. MDIO is split into an output, an output enable and an input, so that the pad or the bench can resolve the line; a released line reads as 1 through the bus pull-up.

On a read, the PHY proves it is present by pulling the line to 0 in the second turnaround bit. If the line stays high, the master keeps clocking with the line released for a recovery period, then ends the read with the error flag set and leaves the read data as they were.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 MDC periods in which MDIO is driven (output enable 1) to 1.
- R2: After the preamble the master drives the start bits 0 then 1, then the opcode: 1,0 for a read (`rd_sel`=1) and 0,1 for a write (`rd_sel`=0).
- R3: Next come the 5 PHY address bits and then the 5 register address bits, each field most significant bit first.
- R4: MDIO output and output enable change only on the system clock where MDC falls (or at the start of the frame) and stay stable while MDC is high.
- R5: On a read, MDIO is released during both turnaround periods. The line level at the end of the second turnaround period must be 0. 16 data bits are then captured most significant bit first, each sampled at the end of the MDC high level, and presented on `rd_data` at `done`.
- R6: If the second turnaround bit of a read is 1, the master clocks 32 further MDC periods with MDIO released. It then finishes with `no_resp`=1 and `rd_data` unchanged.
- R7: After the 16 read data bits, the master clocks `RD_TAIL` (default 2) further MDC periods with MDIO released before `done`.
- R8: On a write, the turnaround is driven as 1 then 0, followed by the 16 bits of `wr_data`, most significant bit first.
- R9: After the last write data bit, MDIO is released for one full MDC period before `done`. MDIO is always released when the block is idle.
- R10: Each MDC level lasts exactly `DIV_HALF` system clocks within a frame, every bit period begins with MDC low, and MDC stays low while idle.
- R11: A `start` pulse while `busy` is 1 is ignored: the frame in progress, including its fields, runs on unchanged.
- R12: `done` is a single-cycle pulse on the cycle `busy` falls. `no_resp` is cleared when a start is accepted and otherwise holds its value until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only when idle |
| rd_sel | input | 1 | 1 selects read, 0 selects write |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Last successfully read data |
| done | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | Frame in progress |
| no_resp | output | 1 | Last read got no turnaround answer |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | Resolved MDIO line level |

## Verification
A bit counter or state that is off by one shifts every later bit period. This shows as a wrong `mdio_oe` or `mdio_o` on the very next MDC low level, or as `done` arriving one bit period early or late. A bad sampling point or shift direction corrupts `rd_data`, which is compared at `done`. A missed or spurious no-response branch changes the frame length by tens of MDC periods. Because the MDC level, the drive enable, the driven bit, `busy` and `done` are compared on every system clock, most faults are reported within one MDC half-period of where they first arise.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVE,
    ST_TA_REL,
    ST_TA_CHK,
    ST_RDATA,
    ST_TAIL,
    ST_RECOV
  } mdio_state_t;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_WRITE = 2'b10;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic slot_end
);
  localparam int CW = $clog2(DIV_HALF + 1);

  logic [CW-1:0] cnt_q;
  logic          phase_q;
  logic          tc;

  assign tc       = (cnt_q == CW'(DIV_HALF - 1));
  assign slot_end = run && phase_q && tc;
  assign mdc      = phase_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (tc) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_txshift.sv
module mdio_txshift #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  output logic         bit_o
);
  logic [W-1:0] sr_q;

  assign bit_o = sr_q[W-1];

  always_ff @(posedge clk) begin
    if (rst)        sr_q <= '0;
    else if (load)  sr_q <= load_val;
    else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
  end
endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
  import mdio_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int PRE_BITS    = 32,
  parameter int RECOV_SLOTS = 32,
  parameter int RD_TAIL     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_sel,
  input  logic              slot_end,
  input  logic              mdio_i,
  output logic              load,
  output logic              shift,
  output logic              busy,
  output logic              oe,
  output logic              done,
  output logic              no_resp,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HDR_BITS = PRE_BITS + 4 + 2 * ADDR_W;
  localparam int WR_BITS  = HDR_BITS + 2 + DATA_W;
  localparam int MAXA     = (WR_BITS > RECOV_SLOTS) ? WR_BITS : RECOV_SLOTS;
  localparam int MAXC     = (MAXA > RD_TAIL) ? MAXA : RD_TAIL;
  localparam int CNT_W    = $clog2(MAXC + 1);

  mdio_state_t       state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              is_rd_q;
  logic [DATA_W-1:0] rx_q;
  logic              last;

  assign load  = start && !busy;
  assign shift = slot_end && (state_q == ST_DRIVE);
  assign last  = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      is_rd_q <= 1'b0;
      rx_q    <= '0;
      busy    <= 1'b0;
      oe      <= 1'b0;
      done    <= 1'b0;
      no_resp <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        state_q <= ST_DRIVE;
        cnt_q   <= rd_sel ? CNT_W'(HDR_BITS) : CNT_W'(WR_BITS);
        is_rd_q <= rd_sel;
        busy    <= 1'b1;
        oe      <= 1'b1;
        no_resp <= 1'b0;
      end else if (slot_end) begin
        cnt_q <= cnt_q - 1'b1;
        unique case (state_q)
          ST_DRIVE: begin
            if (last) begin
              oe <= 1'b0;
              if (is_rd_q) begin
                state_q <= ST_TA_REL;
              end else begin
                state_q <= ST_TAIL;
                cnt_q   <= CNT_W'(1);
              end
            end
          end
          ST_TA_REL: state_q <= ST_TA_CHK;
          ST_TA_CHK: begin
            if (!mdio_i) begin
              state_q <= ST_RDATA;
              cnt_q   <= CNT_W'(DATA_W);
            end else begin
              state_q <= ST_RECOV;
              cnt_q   <= CNT_W'(RECOV_SLOTS);
            end
          end
          ST_RDATA: begin
            rx_q <= {rx_q[DATA_W-2:0], mdio_i};
            if (last) begin
              state_q <= ST_TAIL;
              cnt_q   <= CNT_W'(RD_TAIL);
            end
          end
          ST_TAIL: begin
            if (last) begin
              state_q <= ST_IDLE;
              busy    <= 1'b0;
              done    <= 1'b1;
              if (is_rd_q) rd_data <= rx_q;
            end
          end
          ST_RECOV: begin
            if (last) begin
              state_q <= ST_IDLE;
              busy    <= 1'b0;
              done    <= 1'b1;
              no_resp <= 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_HALF    = 2,
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 16,
  parameter int PRE_BITS    = 32,
  parameter int RECOV_SLOTS = 32,
  parameter int RD_TAIL     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              busy,
  output logic              no_resp,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam int FRAME_W = PRE_BITS + 4 + 2 * ADDR_W + 2 + DATA_W;

  logic               slot_end;
  logic               load;
  logic               shift;
  logic [FRAME_W-1:0] frame;

  assign frame = {{PRE_BITS{1'b1}}, SOF_BITS, (rd_sel ? OP_READ : OP_WRITE),
                  phy_addr, reg_addr, TA_WRITE, wr_data};

  mdio_clkgen #(.DIV_HALF(DIV_HALF)) u_clk (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .mdc      (mdc),
    .slot_end (slot_end)
  );

  mdio_txshift #(.W(FRAME_W)) u_tx (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (frame),
    .shift    (shift),
    .bit_o    (mdio_o)
  );

  mdio_seq #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .PRE_BITS    (PRE_BITS),
    .RECOV_SLOTS (RECOV_SLOTS),
    .RD_TAIL     (RD_TAIL)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .rd_sel   (rd_sel),
    .slot_end (slot_end),
    .mdio_i   (mdio_i),
    .load     (load),
    .shift    (shift),
    .busy     (busy),
    .oe       (mdio_oe),
    .done     (done),
    .no_resp  (no_resp),
    .rd_data  (rd_data)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV_HALF = 2
) (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic no_resp,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe
);
  logic       mdc_prev;
  logic [7:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      mdc_prev <= 1'b0;
      run_len  <= 8'd1;
    end else begin
      mdc_prev <= mdc;
      if (mdc != mdc_prev)    run_len <= 8'd1;
      else if (run_len != '1) run_len <= run_len + 1'b1;
    end
  end

  p_idle_mdc_low_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  p_high_len_r10: assert property (@(posedge clk) disable iff (rst)
    (mdc_prev && !mdc) |-> (run_len == 8'(DIV_HALF)));

  p_idle_released_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdio_oe);

  p_stable_high_r4: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_done_single_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_at_fall_r12: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_err_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (no_resp != $past(no_resp)) |-> (done || $past(start && !busy)));
endmodule

bind mdio_master mdio_master_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .no_resp (no_resp),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  localparam int H       = 2;
  localparam int RD_TAIL = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        rd_sel = 1'b0;
  logic [4:0]  phy_addr = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        done, busy, no_resp, mdc, mdio_o, mdio_oe, mdio_i;
  logic        phy_en = 1'b0;
  logic        phy_v = 1'b0;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [15:0] last_rd = '0;

  always #2 clk = ~clk;

  assign mdio_i = mdio_oe ? mdio_o : (phy_en ? phy_v : 1'b1);

  mdio_master #(.DIV_HALF(H), .RD_TAIL(RD_TAIL)) dut (
    .clk(clk), .rst(rst), .start(start), .rd_sel(rd_sel),
    .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
    .rd_data(rd_data), .done(done), .busy(busy), .no_resp(no_resp),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input bit present,
                         input logic [15:0] rv, input int poke);
    bit e_oe[80];
    bit e_v[80];
    bit p_en[80];
    bit p_v[80];
    string tg[80];
    logic [13:0] hdr;
    logic [17:0] wtl;
    int nslots;
    string tag;
    hdr = {2'b01, (rd ? 2'b10 : 2'b01), pa, ra};
    wtl = {2'b10, wd};
    nslots = !rd ? 65 : (present ? 64 + RD_TAIL : 80);
    for (int s = 0; s < 80; s++) begin
      e_oe[s] = 1'b0; e_v[s] = 1'b0; p_en[s] = 1'b0; p_v[s] = 1'b0;
      if (s < 32) begin
        e_oe[s] = 1'b1; e_v[s] = 1'b1; tg[s] = "R1";
      end else if (s < 46) begin
        e_oe[s] = 1'b1; e_v[s] = hdr[45 - s]; tg[s] = (s < 36) ? "R2" : "R3";
      end else if (!rd) begin
        if (s < 64) begin
          e_oe[s] = 1'b1; e_v[s] = wtl[63 - s]; tg[s] = "R8";
        end else tg[s] = "R9";
      end else if (s < 48) begin
        tg[s] = "R5";
        if (s == 47 && present) begin p_en[s] = 1'b1; p_v[s] = 1'b0; end
      end else if (present) begin
        if (s < 64) begin
          tg[s] = "R5"; p_en[s] = 1'b1; p_v[s] = rv[63 - s];
        end else tg[s] = "R7";
      end else tg[s] = "R6";
    end

    @(negedge clk);
    start = 1'b1; rd_sel = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
    for (int s = 0; s < nslots; s++) begin
      for (int c = 0; c < 2 * H; c++) begin
        @(negedge clk);
        if (s == 0 && c == 0) begin
          start = 1'b0;
          chk("R12", "no_resp cleared at start", no_resp, 0);
        end
        if (poke > 0 && s == poke && c == 0) begin
          start = 1'b1; rd_sel = !rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
        end else if (poke > 0 && s == poke && c == 1) begin
          start = 1'b0;
        end
        if (c == 0) begin phy_en = p_en[s]; phy_v = p_v[s]; end
        tag = (poke > 0 && s >= poke) ? "R11" : tg[s];
        chk((c == 0 || c == H) ? "R10" : tag, "mdc", mdc, (c >= H));
        chk(tag, "mdio_oe", mdio_oe, e_oe[s]);
        if (e_oe[s]) chk(tag, "mdio_o", mdio_o, e_v[s]);
        chk(tag, "busy", busy, 1);
        chk(tag, "done", done, 0);
      end
    end
    phy_en = 1'b0;
    @(negedge clk);
    chk("R12", "done pulse", done, 1);
    chk("R12", "busy low at done", busy, 0);
    chk("R10", "mdc idle", mdc, 0);
    chk("R9", "released at done", mdio_oe, 0);
    if (rd && present) begin
      chk("R5", "rd_data", rd_data, rv);
      last_rd = rv;
    end else if (rd) begin
      chk("R6", "rd_data kept", rd_data, last_rd);
    end
    chk(rd ? (present ? "R5" : "R6") : "R8", "no_resp", no_resp, (rd && !present));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12", "done low after pulse", done, 0);
      chk("R12", "no_resp held", no_resp, (rd && !present));
      chk("R10", "mdc idle low", mdc, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10", "reset mdc", mdc, 0);
    chk("R9", "reset oe", mdio_oe, 0);
    chk("R12", "reset done", done, 0);
    chk("R12", "reset busy", busy, 0);
    chk("R6", "reset no_resp", no_resp, 0);
    chk("R5", "reset rd_data", rd_data, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10", "idle mdc", mdc, 0);

    run_txn(1'b0, 5'h1F, 5'h00, 16'hA5C3, 1'b1, 16'h0000, 0);
    run_txn(1'b1, 5'h11, 5'h0A, 16'h0000, 1'b1, 16'hBEEF, 0);
    run_txn(1'b1, 5'h03, 5'h1E, 16'h0000, 1'b0, 16'h0000, 0);
    repeat (5) @(negedge clk);
    chk("R12", "no_resp held while idle", no_resp, 1);
    run_txn(1'b0, 5'h0C, 5'h15, 16'h8001, 1'b1, 16'h0000, 20);
    run_txn(1'b1, 5'h00, 5'h1F, 16'h0000, 1'b1, 16'h0001, 50);
    run_txn(1'b1, 5'h15, 5'h0A, 16'h0000, 1'b1, 16'h8000, 0);
    run_txn(1'b0, 5'h0A, 5'h15, 16'h7FFE, 1'b1, 16'h0000, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule